// File: doc/BRIEF.md
# Receive Character Buffer with Line and Modem Status

This block takes finished characters from a serial receiver and holds them until a host reads them through a small register port. It works in one of two modes. With buffering off, a single holding register keeps the latest character. With buffering on, a first-in first-out queue keeps up to `FIFO_DEPTH` characters. Each stored character carries the parity-error flag the receiver gave it. The block keeps a line status byte and a modem status byte. The line status byte holds data available, overrun and parity error. The modem status byte holds the clear-to-send level and a clear-to-send change flag. Reading either status byte clears its sticky flags.

The character input is a valid-only stream and has no ready. The receiver cannot be stalled, so the block never pushes back. A character that finds no room is handled by the overrun rules instead:
- In buffered mode the arriving character is dropped and the queue is left unchanged.
- In single-register mode the older, unread character is replaced.

The active-low clear-to-send pin is synchronised before any change is detected. A change can drive a level interrupt output when the host enables it.

Top module: `uart_rx_status`

## Requirements

Register map, selected by `reg_addr`:
- 0: receive data. A read returns the oldest character and removes it.
- 1: control. Bit 0 is buffered mode and bit 1 is the modem interrupt enable. The other bits are ignored on write and read as 0.
- 2: line status. Bit 0 is data available, bit 1 is overrun and bit 2 is parity error. Bits 7:3 read as 0.
- 3: modem status. Bit 0 is the clear-to-send level and bit 1 is the change flag. Bits 7:2 read as 0.

- R1: After reset the control byte and the line status byte read as 0, `irq` is low, and no change flag is raised while the synchroniser settles. The clear-to-send level bit then shows the pin state.
- R2: Line status bit 0 is 1 while at least one character is stored. It returns to 0 once the last stored character has been read from address 0.
- R3: In buffered mode up to `FIFO_DEPTH` characters are kept and read back from address 0 in arrival order.
- R4: In buffered mode, a character that arrives while the queue is full (with no read in the same cycle) sets the overrun bit and is discarded. The stored characters stay intact.
- R5: In single-register mode, a character that arrives while the previous one is unread replaces it and sets the overrun bit.
- R6: Reading line status clears the overrun bit. An overrun in the same cycle as that read leaves the bit set.
- R7: Line status bit 2 shows the parity flag of the character now at the head. A line status read hides it until the head character changes: by a read, or by a new load in single-register mode.
- R8: The modem status level bit is the inverse of `cts_n`. It reflects the pin two clock cycles after the pin changes.
- R9: The change flag sets when the synchronised level changes and clears when modem status is read. A change in the same cycle as that read leaves the flag set.
- R10: `irq` is high exactly when the change flag is set and control bit 1 is 1.
- R11: Writing control bit 0 with a value different from the current mode discards every stored character.

## Ports

| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | One-cycle strobe: a character has finished in the receiver |
| rx_data | input | 8 | Character delivered with `rx_valid` |
| rx_perr | input | 1 | Parity error flag for `rx_data` |
| cts_n | input | 1 | Active-low clear-to-send pin, asynchronous |
| reg_rd | input | 1 | Register read strobe; side effects take place at the clock edge |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, valid in the same cycle |
| irq | output | 1 | Modem status interrupt, level |

## Verification

The bench builds the block with its defaults: a 16-entry queue and a two-stage synchroniser. The full 16-entry queue can be filled quickly, which makes the buffered overrun case easy to test, including the case where the overrun and the line status read share a cycle. The two-stage delay gives a known cycle in which a pin change lands, so the bench can place a modem status read in exactly the cycle where the change flag is set.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int CHAR_W = 8;

  typedef enum logic [1:0] {
    A_RXDATA = 2'd0,
    A_CTRL   = 2'd1,
    A_LINE   = 2'd2,
    A_MODEM  = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic              perr;
    logic [CHAR_W-1:0] data;
  } rx_char_t;
endpackage

// File: rtl/rx_fifo.sv
module rx_fifo
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic                         push,
  input  rx_char_t                     push_char,
  input  logic                         pop,
  output rx_char_t                     head,
  output logic                         empty,
  output logic                         full,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH-1);

  rx_char_t      mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt_q;
  logic          do_pop, do_push;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign count   = cnt_q;
  assign do_pop  = pop && !empty;
  assign do_push = push && (!full || do_pop);
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_char;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/rx_line_ctrl.sv
module rx_line_ctrl
  import uart_rx_pkg::*;
#(
  parameter int FIFO_DEPTH = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              fifo_mode,
  input  logic                              flush,
  input  logic                              in_valid,
  input  rx_char_t                          in_char,
  input  logic                              rd_data,
  input  logic                              rd_line,
  output rx_char_t                          head_char,
  output logic                              avail,
  output logic                              ovr,
  output logic                              perr_flag,
  output logic                              ovr_evt,
  output logic [$clog2(FIFO_DEPTH+1)-1:0]   fifo_count
);
  localparam int CW = $clog2(FIFO_DEPTH+1);

  rx_char_t      fifo_head;
  logic          fifo_empty, fifo_full;
  logic [CW-1:0] fifo_cnt;
  logic          f_push, f_pop;

  rx_char_t hold_q;
  logic     hold_valid;
  logic     h_load, h_loss;
  logic     fifo_ovr;
  logic     head_change;
  logic     pe_ack;

  assign f_push = in_valid && fifo_mode;
  assign f_pop  = rd_data && fifo_mode;

  rx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .push      (f_push),
    .push_char (in_char),
    .pop       (f_pop),
    .head      (fifo_head),
    .empty     (fifo_empty),
    .full      (fifo_full),
    .count     (fifo_cnt)
  );

  // single-register path
  assign h_load = in_valid && !fifo_mode;
  assign h_loss = h_load && hold_valid && !rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q     <= '0;
      hold_valid <= 1'b0;
    end else if (flush) begin
      hold_valid <= 1'b0;
    end else if (h_load) begin
      hold_q     <= in_char;
      hold_valid <= 1'b1;
    end else if (rd_data && !fifo_mode) begin
      hold_valid <= 1'b0;
    end
  end

  // overrun: buffered mode drops the arriving character
  assign fifo_ovr = f_push && fifo_full && !(f_pop && !fifo_empty);
  assign ovr_evt  = fifo_mode ? fifo_ovr : h_loss;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ovr <= 1'b0;
    else if (ovr_evt) ovr <= 1'b1;
    else if (rd_line) ovr <= 1'b0;
  end

  // parity: head flag, masked by a status read until the head moves
  assign head_change = fifo_mode ? ((f_pop && !fifo_empty) || (f_push && fifo_empty))
                                 : h_load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        pe_ack <= 1'b0;
    else if (flush || head_change)     pe_ack <= 1'b0;
    else if (rd_line)                  pe_ack <= 1'b1;
  end

  assign head_char  = fifo_mode ? fifo_head : hold_q;
  assign avail      = fifo_mode ? !fifo_empty : hold_valid;
  assign perr_flag  = avail && head_char.perr && !pe_ack;
  assign fifo_count = fifo_cnt;
endmodule

// File: rtl/cts_monitor.sv
module cts_monitor #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cts_n,
  input  logic clr,
  output logic cts_level,
  output logic dcts,
  output logic changed
);
  localparam int ARM    = SYNC_STAGES + 1;
  localparam int ARM_W  = $clog2(ARM + 1);

  logic [SYNC_STAGES:0] chain;
  logic [ARM_W-1:0]     arm_cnt;
  logic                 armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[SYNC_STAGES-1:0], ~cts_n};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      arm_cnt <= '0;
    else if (arm_cnt != ARM_W'(ARM)) arm_cnt <= arm_cnt + 1'b1;
  end

  assign armed     = (arm_cnt == ARM_W'(ARM));
  assign cts_level = chain[SYNC_STAGES-1];
  assign changed   = armed && (chain[SYNC_STAGES-1] != chain[SYNC_STAGES]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dcts <= 1'b0;
    else if (changed) dcts <= 1'b1;
    else if (clr)     dcts <= 1'b0;
  end
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import uart_rx_pkg::*;
#(
  parameter int FIFO_DEPTH  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        rx_perr,
  input  logic        cts_n,
  input  logic        reg_rd,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  output logic        irq
);
  localparam int CNT_W = $clog2(FIFO_DEPTH+1);

  reg_addr_e   addr;
  logic        fifo_en, msi_en;
  logic        flush;
  logic        rd_data, rd_line, rd_modem;
  rx_char_t    in_char, head_char;
  logic        avail, ovr, perr_flag, ovr_evt;
  logic [CNT_W-1:0] fifo_count;
  logic        cts_level, dcts, cts_changed;
  logic        unused_wdata;

  assign addr         = reg_addr_e'(reg_addr);
  assign unused_wdata = ^reg_wdata[7:2];
  assign rd_data      = reg_rd && (addr == A_RXDATA);
  assign rd_line      = reg_rd && (addr == A_LINE);
  assign rd_modem     = reg_rd && (addr == A_MODEM);
  assign flush        = reg_wr && (addr == A_CTRL) && (reg_wdata[0] != fifo_en);
  assign in_char      = '{perr: rx_perr, data: rx_data};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_en <= 1'b0;
      msi_en  <= 1'b0;
    end else if (reg_wr && addr == A_CTRL) begin
      fifo_en <= reg_wdata[0];
      msi_en  <= reg_wdata[1];
    end
  end

  rx_line_ctrl #(.FIFO_DEPTH(FIFO_DEPTH)) u_line (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_mode  (fifo_en),
    .flush      (flush),
    .in_valid   (rx_valid),
    .in_char    (in_char),
    .rd_data    (rd_data),
    .rd_line    (rd_line),
    .head_char  (head_char),
    .avail      (avail),
    .ovr        (ovr),
    .perr_flag  (perr_flag),
    .ovr_evt    (ovr_evt),
    .fifo_count (fifo_count)
  );

  cts_monitor #(.SYNC_STAGES(SYNC_STAGES)) u_cts (
    .clk       (clk),
    .rst_n     (rst_n),
    .cts_n     (cts_n),
    .clr       (rd_modem),
    .cts_level (cts_level),
    .dcts      (dcts),
    .changed   (cts_changed)
  );

  always_comb begin
    unique case (addr)
      A_RXDATA: reg_rdata = avail ? head_char.data : 8'h00;
      A_CTRL:   reg_rdata = {6'b0, msi_en, fifo_en};
      A_LINE:   reg_rdata = {5'b0, perr_flag, ovr, avail};
      A_MODEM:  reg_rdata = {6'b0, dcts, cts_level};
      default:  reg_rdata = 8'h00;
    endcase
  end

  assign irq = dcts && msi_en;
endmodule

// File: rtl/uart_rx_status_chk.sv
module uart_rx_status_chk #(
  parameter int FIFO_DEPTH = 16
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            rx_valid,
  input logic                            reg_rd,
  input logic [1:0]                      reg_addr,
  input logic [7:0]                      reg_rdata,
  input logic                            irq,
  input logic                            msi_en,
  input logic                            ovr,
  input logic                            ovr_evt,
  input logic                            dcts,
  input logic                            cts_changed,
  input logic [$clog2(FIFO_DEPTH+1)-1:0] fifo_count
);
  // R3
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= ($clog2(FIFO_DEPTH+1))'(FIFO_DEPTH));

  // R2
  dr_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 2'd2 && !reg_rdata[0]) |-> (fifo_count == '0));

  // R6
  ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 2'd2 && !ovr_evt) |=> !ovr);

  // R6
  ovr_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> $past(rx_valid));

  // R9
  msr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 2'd3) |-> (reg_rdata[7:2] == 6'b0));

  // R9
  dcts_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cts_changed |=> dcts);

  // R9
  dcts_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 2'd3 && !cts_changed) |=> !dcts);

  // R10
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !msi_en |-> !irq);
endmodule

bind uart_rx_status uart_rx_status_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rx_valid    (rx_valid),
  .reg_rd      (reg_rd),
  .reg_addr    (reg_addr),
  .reg_rdata   (reg_rdata),
  .irq         (irq),
  .msi_en      (msi_en),
  .ovr         (ovr),
  .ovr_evt     (ovr_evt),
  .dcts        (dcts),
  .cts_changed (cts_changed),
  .fifo_count  (fifo_count)
);

// File: tb/test_uart_rx_status.sv
module test_uart_rx_status;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic       rx_perr = 1'b0;
  logic       cts_n = 1'b0;
  logic       reg_rd = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  localparam logic [1:0] RX = 2'd0, CT = 2'd1, LS = 2'd2, MS = 2'd3;

  always #5 clk = ~clk;

  uart_rx_status i_uart_rx_status (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_perr(rx_perr), .cts_n(cts_n), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [1:0] a, logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic put(logic [7:0] d, logic p);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = d; rx_perr = p;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic t_reset;
    repeat (6) @(negedge clk);
    check("R1 irq", {7'b0, irq}, 8'h00);
    rd_chk("R1 line", LS, 8'h00);
    rd_chk("R1 ctrl", CT, 8'h00);
    rd_chk("R1/R8 modem", MS, 8'h01);
  endtask

  task automatic t_single;
    put(8'h5A, 1'b0);
    rd_chk("R2 ready set", LS, 8'h01);
    rd_chk("R2 data", RX, 8'h5A);
    rd_chk("R2 ready clear", LS, 8'h00);
    put(8'h11, 1'b0);
    put(8'h22, 1'b0);
    rd_chk("R5 overrun", LS, 8'h03);
    rd_chk("R5 newest kept", RX, 8'h22);
    rd_chk("R6 overrun cleared", LS, 8'h00);
  endtask

  task automatic t_single_parity;
    put(8'h33, 1'b1);
    rd_chk("R7 parity shown", LS, 8'h05);
    rd_chk("R7 parity hidden", LS, 8'h01);
    put(8'h44, 1'b1);
    rd_chk("R7 new load reports", LS, 8'h07);
    rd_chk("R7 data", RX, 8'h44);
    rd_chk("R7 empty", LS, 8'h00);
  endtask

  task automatic t_fifo;
    put(8'h77, 1'b0);
    wr(CT, 8'h01);
    rd_chk("R11 flush", LS, 8'h00);
    rd_chk("R11 ctrl", CT, 8'h01);
    for (int i = 0; i < 16; i++) put(8'(i * 7 + 3), 1'b0);
    rd_chk("R3 ready", LS, 8'h01);
    put(8'hEE, 1'b0);
    rd_chk("R4 overrun", LS, 8'h03);
    for (int i = 0; i < 16; i++) rd_chk("R3/R4 order", RX, 8'(i * 7 + 3));
    rd_chk("R2 drained", LS, 8'h00);
  endtask

  task automatic t_fifo_parity;
    put(8'hA1, 1'b0);
    put(8'hB2, 1'b1);
    rd_chk("R7 good head", LS, 8'h01);
    rd_chk("R7 data A1", RX, 8'hA1);
    rd_chk("R7 bad head", LS, 8'h05);
    rd_chk("R7 acked", LS, 8'h01);
    rd_chk("R7 data B2", RX, 8'hB2);
    rd_chk("R7 empty", LS, 8'h00);
  endtask

  task automatic t_ovr_collision;
    logic [7:0] v;
    for (int i = 0; i < 16; i++) put(8'(8'h40 + i), 1'b0);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = 8'hFF; rx_perr = 1'b0;
    reg_rd = 1'b1; reg_addr = LS;
    #1 v = reg_rdata;
    @(negedge clk);
    rx_valid = 1'b0; reg_rd = 1'b0;
    check("R6 before", v, 8'h01);
    rd_chk("R6 set wins", LS, 8'h03);
    for (int i = 0; i < 16; i++) rd_chk("R4 intact", RX, 8'(8'h40 + i));
    rd_chk("R6 cleared", LS, 8'h00);
  endtask

  task automatic t_cts;
    @(negedge clk); cts_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 masked", {7'b0, irq}, 8'h00);
    rd_chk("R8/R9 negated+delta", MS, 8'h02);
    rd_chk("R9 cleared", MS, 8'h00);
    wr(CT, 8'h03);
    @(negedge clk); cts_n = 1'b0;
    repeat (4) @(negedge clk);
    check("R10 irq high", {7'b0, irq}, 8'h01);
    rd_chk("R8/R9 asserted+delta", MS, 8'h03);
    check("R10 irq low", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_cts_collision;
    @(negedge clk); cts_n = 1'b1;
    @(negedge clk);
    rd_chk("R9 read in set cycle", MS, 8'h00);
    rd_chk("R9 set wins", MS, 8'h02);
    rd_chk("R9 cleared after", MS, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_single;
    t_single_parity;
    t_fifo;
    t_fifo_parity;
    t_ovr_collision;
    t_cts;
    t_cts_collision;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule